// File: doc/BRIEF.md
# Free-Running Timer With Coherent Byte Reads

This block is a free-running up-counter that sits behind an 8-bit register bus. A fixed prescaler divides the bus clock, and the counter advances once per prescaler period. The counter wraps at its all-ones value and never stops. Software reads the count one byte at a time through either of two identical byte pairs.

If the high byte is read first, the block copies the low byte into a holding buffer at that moment. The later low-byte read returns that copy, so the two halves belong to the same count value. Both pairs share one buffer and one open-sequence state.

A wrap sets an overflow flag. The flag drives an interrupt output through a writable enable bit. The flag is cleared by reading the status register while the flag is set and then reading the main pair's low byte. The alternate pair gives the same count and never touches the flag, so background code can read the time without losing an overflow event.

Top module: `frc_timer`

## Requirements
- R1: After reset the count is zero, the overflow flag and the enable bit are zero, `irq_o` is low, and no read sequence is open.
- R2: The count increases by one every PRESCALE clock cycles (default 4), counted from reset release, and wraps from all ones to zero.
- R3: When no sequence is open, a read of either low-byte address (0x19 main, 0x1B alternate) returns the live low byte of the count.
- R4: A read of either high-byte address (0x18 main, 0x1A alternate) returns the live high byte. If no sequence is open, the read also copies the live low byte into the buffer and opens a sequence.
- R5: While a sequence is open, further high-byte reads do not reload the buffer.
- R6: While a sequence is open, a read of either low-byte address returns the buffered byte and closes the sequence.
- R7: Reads, and writes to the counter addresses, never change the count.
- R8: The overflow flag, seen at bit 0 of the status register at 0x13, becomes 1 on the clock edge where the count wraps to zero.
- R9: A status read while the flag is 1, followed by a read of 0x19, clears the flag.
- R10: A read of 0x1B never changes the overflow flag and does not cancel a pending clear.
- R11: If the count wraps on the same edge as a clearing read of 0x19, the flag stays 1.
- R12: The control register at 0x12 is writable and readable. Its bit 0 enables the interrupt, and `irq_o` equals the overflow flag ANDed with that bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rd_i | input | 1 | Read strobe, one cycle per access |
| wr_i | input | 1 | Write strobe, one cycle per access |
| addr_i | input | ADDR_W | Register address |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data, valid in the strobe cycle; zero when idle |
| irq_o | output | 1 | Overflow interrupt request |

## Verification
The bench builds the block with a 4-bit data bus, which gives an 8-bit counter, and keeps the default prescale of four. The count then wraps every 1024 clock cycles, so the bench reaches three wraps in a few thousand cycles. This puts the set, clear and clear-versus-wrap collision of the overflow flag within reach of a short directed run. The bench predicts every count from the number of edges since reset release. It places the colliding clear read in the exact cycle before a wrap edge.

// File: rtl/frc_timer_pkg.sv
package frc_timer_pkg;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_CTRL,
    SEL_STAT,
    SEL_MAIN_HI,
    SEL_MAIN_LO,
    SEL_ALT_HI,
    SEL_ALT_LO
  } frc_sel_e;

  localparam int IE_BIT  = 0;
  localparam int TOF_BIT = 0;

endpackage

// File: rtl/frc_prescale.sv
module frc_prescale #(
  parameter int DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);

  generate
    if (DIV <= 1) begin : g_bypass
      assign tick_o = 1'b1;
    end else begin : g_div
      localparam int PW = $clog2(DIV);
      logic [PW-1:0] pre_q;

      assign tick_o = (pre_q == PW'(DIV - 1));

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)     pre_q <= '0;
        else if (tick_o) pre_q <= '0;
        else             pre_q <= pre_q + PW'(1);
      end
    end
  endgenerate

endmodule

// File: rtl/frc_counter.sv
module frc_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);

  logic [CNT_W-1:0] cnt_q;

  assign cnt_o  = cnt_q;
  assign wrap_o = inc_i & (&cnt_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (inc_i) cnt_q <= cnt_q + CNT_W'(1);
  end

endmodule

// File: rtl/frc_rd_latch.sv
// One buffer shared by both byte pairs; first high read opens the sequence.
module frc_rd_latch #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hi_rd_i,
  input  logic              lo_rd_i,
  input  logic [DATA_W-1:0] live_lo_i,
  output logic [DATA_W-1:0] lo_o,
  output logic [DATA_W-1:0] buf_o,
  output logic              open_o
);

  logic [DATA_W-1:0] buf_q;
  logic              open_q;

  assign lo_o   = open_q ? buf_q : live_lo_i;
  assign buf_o  = buf_q;
  assign open_o = open_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      buf_q  <= '0;
      open_q <= 1'b0;
    end else if (hi_rd_i && !open_q) begin
      buf_q  <= live_lo_i;
      open_q <= 1'b1;
    end else if (lo_rd_i) begin
      open_q <= 1'b0;
    end
  end

endmodule

// File: rtl/frc_ovf_flag.sv
module frc_ovf_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wrap_i,
  input  logic stat_rd_i,
  input  logic clr_rd_i,
  output logic tof_o
);

  logic tof_q;
  logic arm_q;

  assign tof_o = tof_q;

  // wrap beats a clear landing on the same edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   tof_q <= 1'b0;
    else if (wrap_i)               tof_q <= 1'b1;
    else if (clr_rd_i && arm_q)    tof_q <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   arm_q <= 1'b0;
    else if (stat_rd_i && tof_q)   arm_q <= 1'b1;
    else if (clr_rd_i)             arm_q <= 1'b0;
  end

endmodule

// File: rtl/frc_timer.sv
module frc_timer
  import frc_timer_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int ADDR_W      = 8,
  parameter int PRESCALE    = 4,
  parameter int ADDR_CTRL   = 'h12,
  parameter int ADDR_STAT   = 'h13,
  parameter int ADDR_MAIN_HI = 'h18,
  parameter int ADDR_MAIN_LO = 'h19,
  parameter int ADDR_ALT_HI  = 'h1A,
  parameter int ADDR_ALT_LO  = 'h1B
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);

  localparam int CNT_W = 2 * DATA_W;

  frc_sel_e          sel;
  logic              tick;
  logic [CNT_W-1:0]  cnt;
  logic              wrap;
  logic              hi_rd;
  logic              lo_rd;
  logic [DATA_W-1:0] lo_byte;
  logic [DATA_W-1:0] lo_buf;
  logic              seq_open;
  logic              tof;
  logic [DATA_W-1:0] ctrl_q;
  logic [DATA_W-1:0] stat_word;

  always_comb begin
    case (addr_i)
      ADDR_W'(ADDR_CTRL):    sel = SEL_CTRL;
      ADDR_W'(ADDR_STAT):    sel = SEL_STAT;
      ADDR_W'(ADDR_MAIN_HI): sel = SEL_MAIN_HI;
      ADDR_W'(ADDR_MAIN_LO): sel = SEL_MAIN_LO;
      ADDR_W'(ADDR_ALT_HI):  sel = SEL_ALT_HI;
      ADDR_W'(ADDR_ALT_LO):  sel = SEL_ALT_LO;
      default:               sel = SEL_NONE;
    endcase
  end

  assign hi_rd = rd_i && (sel == SEL_MAIN_HI || sel == SEL_ALT_HI);
  assign lo_rd = rd_i && (sel == SEL_MAIN_LO || sel == SEL_ALT_LO);

  frc_prescale #(.DIV(PRESCALE)) u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_o (tick)
  );

  frc_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .inc_i  (tick),
    .cnt_o  (cnt),
    .wrap_o (wrap)
  );

  frc_rd_latch #(.DATA_W(DATA_W)) u_latch (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .hi_rd_i   (hi_rd),
    .lo_rd_i   (lo_rd),
    .live_lo_i (cnt[DATA_W-1:0]),
    .lo_o      (lo_byte),
    .buf_o     (lo_buf),
    .open_o    (seq_open)
  );

  frc_ovf_flag u_ovf (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wrap_i    (wrap),
    .stat_rd_i (rd_i && sel == SEL_STAT),
    .clr_rd_i  (rd_i && sel == SEL_MAIN_LO),
    .tof_o     (tof)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      ctrl_q <= '0;
    else if (wr_i && sel == SEL_CTRL) ctrl_q <= wdata_i;
  end

  always_comb begin
    stat_word          = '0;
    stat_word[TOF_BIT] = tof;
  end

  always_comb begin
    rdata_o = '0;
    if (rd_i) begin
      case (sel)
        SEL_CTRL:                rdata_o = ctrl_q;
        SEL_STAT:                rdata_o = stat_word;
        SEL_MAIN_HI, SEL_ALT_HI: rdata_o = cnt[CNT_W-1:DATA_W];
        SEL_MAIN_LO, SEL_ALT_LO: rdata_o = lo_byte;
        default:                 rdata_o = '0;
      endcase
    end
  end

  assign irq_o = tof & ctrl_q[IE_BIT];

endmodule

// File: rtl/frc_timer_chk.sv
module frc_timer_chk #(
  parameter int DATA_W      = 8,
  parameter int ADDR_W      = 8,
  parameter int PRESCALE    = 4,
  parameter int ADDR_MAIN_HI = 'h18,
  parameter int ADDR_ALT_HI  = 'h1A,
  parameter int ADDR_MAIN_LO = 'h19,
  parameter int ADDR_ALT_LO  = 'h1B
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  rd_i,
  input logic [ADDR_W-1:0]     addr_i,
  input logic [2*DATA_W-1:0]   cnt_i,
  input logic                  tof_i,
  input logic                  seq_i,
  input logic [DATA_W-1:0]     buf_i
);

  localparam int CNT_W = 2 * DATA_W;

  logic hi_rd, lo_rd, alt_lo_rd;
  assign hi_rd     = rd_i && (addr_i == ADDR_W'(ADDR_MAIN_HI) || addr_i == ADDR_W'(ADDR_ALT_HI));
  assign lo_rd     = rd_i && (addr_i == ADDR_W'(ADDR_MAIN_LO) || addr_i == ADDR_W'(ADDR_ALT_LO));
  assign alt_lo_rd = rd_i && (addr_i == ADDR_W'(ADDR_ALT_LO));

  AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_i != $past(cnt_i)) |-> (cnt_i == $past(cnt_i) + CNT_W'(1))); // R2

  generate
    if (PRESCALE > 1) begin : g_spacing
      AST_CNT_SPACING: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cnt_i != $past(cnt_i)) |=> $stable(cnt_i)); // R2
    end
  endgenerate

  AST_TOF_ON_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(cnt_i) == '1 && cnt_i == '0) |-> tof_i); // R8

  AST_TOF_RISE_AT_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tof_i) |-> (cnt_i == '0)); // R8

  AST_SEQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seq_i && hi_rd) |=> $stable(buf_i)); // R5

  AST_LO_CLOSES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lo_rd |=> !seq_i); // R6

  AST_ALT_KEEPS_TOF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alt_lo_rd && tof_i) |=> tof_i); // R10

endmodule

bind frc_timer frc_timer_chk #(
  .DATA_W      (DATA_W),
  .ADDR_W      (ADDR_W),
  .PRESCALE    (PRESCALE),
  .ADDR_MAIN_HI (ADDR_MAIN_HI),
  .ADDR_ALT_HI  (ADDR_ALT_HI),
  .ADDR_MAIN_LO (ADDR_MAIN_LO),
  .ADDR_ALT_LO  (ADDR_ALT_LO)
) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .rd_i   (rd_i),
  .addr_i (addr_i),
  .cnt_i  (cnt),
  .tof_i  (tof),
  .seq_i  (seq_open),
  .buf_i  (lo_buf)
);

// File: tb/frc_timer_bench.sv
module frc_timer_bench;

  localparam int DW  = 4;
  localparam int AW  = 8;
  localparam int DIV = 4;
  localparam int CW  = 2 * DW;
  localparam int MOD = 1 << CW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          rd = 1'b0;
  logic          wr = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic          irq;

  int checks = 0;
  int errors = 0;
  int unsigned e = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  always @(posedge clk) if (rst_n) e <= e + 1;

  frc_timer #(.DATA_W(DW), .ADDR_W(AW), .PRESCALE(DIV)) u_frc_timer (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .rd_i    (rd),
    .wr_i    (wr),
    .addr_i  (addr),
    .wdata_i (wdata),
    .rdata_o (rdata),
    .irq_o   (irq)
  );

  function automatic int cnt_at(int unsigned edges);
    return int'((edges / DIV) % MOD);
  endfunction
  function automatic int lo_at(int unsigned edges);
    return cnt_at(edges) & ((1 << DW) - 1);
  endfunction
  function automatic int hi_at(int unsigned edges);
    return cnt_at(edges) >> DW;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h at edge %0d", req, act, exp, e);
    end
  endtask

  // all tasks start and end just after a falling edge
  task automatic bus_rd(input int a, output int d, output int unsigned at);
    rd = 1'b1; addr = AW'(a);
    #1 d = int'(rdata); at = e;
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic bus_wr(input int a, input int v);
    wr = 1'b1; addr = AW'(a); wdata = DW'(v);
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic wait_until(input int unsigned t);
    while (e < t) @(negedge clk);
  endtask

  task automatic t_reset;
    int d; int unsigned at;
    #1 check("R1 irq", int'(irq), 0);
    bus_rd('h19, d, at); check("R1 count low", d, 0);
    bus_rd('h18, d, at); check("R1 count high", d, 0);
    bus_rd('h19, d, at); check("R1 lo after hi", d, lo_at(at));
    bus_rd('h13, d, at); check("R1 status", d, 0);
    bus_rd('h12, d, at); check("R1 ctrl", d, 0);
  endtask

  task automatic t_count;
    int d; int unsigned at;
    for (int k = 0; k < 6; k++) begin
      repeat (k + 1) @(negedge clk);
      bus_rd('h19, d, at); check("R2 live count", d, lo_at(at));
    end
  endtask

  task automatic t_live_both;
    int d; int unsigned at;
    bus_rd('h19, d, at); check("R3 main low", d, lo_at(at));
    repeat (5) @(negedge clk);
    bus_rd('h1B, d, at); check("R3 alt low", d, lo_at(at));
  endtask

  task automatic t_sequence;
    int d, held; int unsigned at, at0;
    wait_until(200);
    bus_rd('h18, d, at0); check("R4 high live", d, hi_at(at0));
    held = lo_at(at0);
    repeat (9) @(negedge clk);
    bus_rd('h1A, d, at); check("R5 second high live", d, hi_at(at));
    repeat (13) @(negedge clk);
    bus_rd('h19, d, at); check("R6 buffered low", d, held);
    bus_rd('h19, d, at); check("R6 closed, live low", d, lo_at(at));
    // alternate high opens, main low closes
    wait_until(330);
    bus_rd('h1A, d, at0); check("R4 alt high", d, hi_at(at0));
    held = lo_at(at0);
    repeat (7) @(negedge clk);
    bus_rd('h19, d, at); check("R6 cross-pair low", d, held);
  endtask

  task automatic t_no_disturb;
    int d; int unsigned at;
    bus_wr('h19, 'hA);
    bus_wr('h18, 'h5);
    repeat (3) @(negedge clk);
    bus_rd('h18, d, at); check("R7 high after writes", d, hi_at(at));
    bus_rd('h1B, d, at); check("R7 low after writes", d, lo_at(at - 1));
    repeat (2) @(negedge clk);
    bus_rd('h19, d, at); check("R7 live after reads", d, lo_at(at));
  endtask

  task automatic t_overflow;
    int d; int unsigned at;
    wait_until(MOD * DIV - 4);
    bus_rd('h13, d, at); check("R8 flag before wrap", d, 0);
    wait_until(MOD * DIV + 1);
    bus_rd('h13, d, at); check("R8 flag after wrap", d, 1);
    bus_rd('h1B, d, at);
    bus_rd('h13, d, at); check("R10 alt low keeps flag", d, 1);
    bus_rd('h1B, d, at);
    bus_rd('h19, d, at);
    bus_rd('h13, d, at); check("R9 flag cleared", d, 0);
  endtask

  task automatic t_irq;
    int d; int unsigned at;
    bus_wr('h12, 1);
    #1 check("R12 irq needs flag", int'(irq), 0);
    bus_rd('h12, d, at); check("R12 ctrl readback", d, 1);
    wait_until(2 * MOD * DIV + 2);
    #1 check("R12 irq raised", int'(irq), 1);
    bus_wr('h12, 0);
    #1 check("R12 irq masked", int'(irq), 0);
    bus_rd('h13, d, at); check("R12 flag still set", d, 1);
  endtask

  task automatic t_collision;
    int d; int unsigned at;
    bus_rd('h13, d, at);
    wait_until(3 * MOD * DIV - 1);
    bus_rd('h19, d, at); check("R11 read in wrap cycle", int'(at), 3 * MOD * DIV - 1);
    bus_rd('h13, d, at); check("R11 flag survives", d, 1);
    bus_rd('h19, d, at);
    bus_rd('h13, d, at); check("R9 clear after collision", d, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_count;
    t_live_both;
    t_sequence;
    t_no_disturb;
    t_overflow;
    t_irq;
    t_collision;
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule